// File: doc/BRIEF.md
# Iterative IDEA Block Cipher Engine

This block encrypts or decrypts one 64-bit block with the IDEA cipher. It holds a single round datapath and runs it once per clock cycle. Eight full rounds are followed by a reduced output step. The 64-bit block is treated as four 16-bit words. Each round mixes three operations: XOR, addition modulo 2^16 and multiplication modulo 2^16+1. In the multiplication, the operand value 0 stands for 2^16.

The engine does not expand keys. In every busy cycle it shows the current round index on `key_round` and latches the direction on `key_dec`. An external subkey provider must then place the six 16-bit subkeys for that round on `subkeys` within the same cycle. For the output step only the first four subkeys are used. Decryption uses the same datapath and differs only in the subkey sequence the provider returns. A block takes ten clock edges from an accepted start to a one-cycle `done` pulse. At 100 MHz this is 640 Mb/s.

Top module: `idea_iter_core`

## Requirements
- R1: After reset, `busy`, `done`, `key_dec`, `key_round` and `dout` are all zero.
- R2: A `start` that is sampled high while `busy` is low loads `din`. On the next cycle `busy` is 1, `key_round` is 1 and `key_dec` equals the sampled `mode_dec`.
- R3: While busy, `key_round` rises by one each cycle from 1 to 9. Values 1 to 8 select a full round and 9 selects the output step.
- R4: `subkeys` carries K1 in bits 95:80, then K2, K3, K4 and K5, with K6 in bits 15:0. A full round on words (X1,X2,X3,X4) forms a=X1·K1, b=X2+K2, c=X3+K3, d=X4·K4, t0=(a^c)·K5, t1=(t0+(b^d))·K6 and t2=t0+t1. Its result is (a^t1, c^t1, b^t2, d^t2). X1 is in bits 63:48 of the block.
- R5: After rounds 1 to 7 the result passes on as written in R4. After round 8 the two middle words go back to the order (a^t1, b^t2, c^t1, d^t2).
- R6: The output step gives Y1=X1·K1, Y2=X2+K2, Y3=X3+K3 and Y4=X4·K4. `done` is high for exactly one cycle, the cycle after `key_round` showed 9. In that cycle `busy` and `key_round` are 0.
- R7: A `start` that arrives while busy has no effect. The round count, `key_dec` and the result are unchanged.
- R8: `dout` holds its value from `done` until the next accepted `start`, whatever `din` does.
- R9: The same datapath recovers the plaintext when it is given the decryption subkey sequence.
- R10: Multiplication modulo 65537 treats an operand or product value of 0 as 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a block when idle |
| mode_dec | input | 1 | 1 = decrypt, latched on start |
| din | input | 64 | Input block, X1 in the top word |
| subkeys | input | 96 | K1..K6 for the round on key_round, K1 in the top word |
| key_round | output | 4 | Round index 1-9 while busy, 0 when idle |
| key_dec | output | 1 | Latched direction for the subkey provider |
| busy | output | 1 | Block in progress |
| done | output | 1 | One-cycle result pulse |
| dout | output | 64 | Result block |

## Verification
A wrong round counter appears on `key_round` within one cycle. It also moves the `done` pulse away from its fixed point ten edges after start. A fault in a multiplier, adder, the word swap or the output step changes `dout` at `done`. Such a fault is caught by the comparison with an independent bench model, by a published known-answer vector, and by the encrypt-then-decrypt round trip. A `start` that leaks in while busy would restart `key_round` at 1, corrupt the result, or move `dout` while the block is idle.

// File: rtl/idea_iter_core.sv
module idea_iter_core #(
  parameter int W      = 16,
  parameter int ROUNDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode_dec,
  input  logic [4*W-1:0]    din,
  input  logic [6*W-1:0]    subkeys,
  output logic [3:0]        key_round,
  output logic              key_dec,
  output logic              busy,
  output logic              done,
  output logic [4*W-1:0]    dout
);
  localparam int BW = 4*W;
  localparam logic [3:0] LAST = 4'(ROUNDS + 1);
  localparam logic [2*W+1:0] MODV = {{(W+1){1'b0}}, 1'b1, {(W-1){1'b0}}, 1'b1};

  function automatic logic [W-1:0] mmul(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] xa, ya;
    logic [2*W+1:0] p, m;
    xa = (x == '0) ? {1'b1, {W{1'b0}}} : {1'b0, x};
    ya = (y == '0) ? {1'b1, {W{1'b0}}} : {1'b0, y};
    p  = (2*W+2)'(xa) * (2*W+2)'(ya);
    m  = p % MODV;
    return m[W-1:0];
  endfunction

  logic [BW-1:0] st;
  logic [3:0]    rnd;
  logic [W-1:0]  x1, x2, x3, x4, k1, k2, k3, k4, k5, k6;
  logic [W-1:0]  a, b, c, d, t0, t1, t2;
  logic [BW-1:0] nxt;

  assign {x1, x2, x3, x4} = st;
  assign {k1, k2, k3, k4, k5, k6} = subkeys;

  always_comb begin
    a  = mmul(x1, k1);
    b  = x2 + k2;
    c  = x3 + k3;
    d  = mmul(x4, k4);
    t0 = mmul(a ^ c, k5);
    t1 = mmul(t0 + (b ^ d), k6);
    t2 = t0 + t1;
    if (rnd == LAST)
      nxt = {a, b, c, d};
    else if (rnd == 4'(ROUNDS))
      nxt = {a ^ t1, b ^ t2, c ^ t1, d ^ t2};
    else
      nxt = {a ^ t1, c ^ t1, b ^ t2, d ^ t2};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= '0;
      rnd  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
      key_dec <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          st      <= din;
          rnd     <= 4'd1;
          busy    <= 1'b1;
          key_dec <= mode_dec;
        end
      end else begin
        st <= nxt;
        if (rnd == LAST) begin
          rnd  <= '0;
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          rnd <= rnd + 4'd1;
        end
      end
    end
  end

  assign key_round = rnd;
  assign dout      = st;

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && key_round == 4'd1));
  // R3
  round_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_round != LAST) |=> (busy && key_round == $past(key_round) + 4'd1));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R6
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_round == LAST) |=> (done && !busy));
  // R7
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && key_round != LAST) |=> $stable(key_dec));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(dout));
endmodule

// File: tb/sim_idea_iter_core.sv
module sim_idea_iter_core;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_dec = 1'b0;
  logic [63:0] din = '0;
  logic [95:0] subkeys;
  logic [3:0]  key_round;
  logic key_dec, busy, done;
  logic [63:0] dout;
  int checks = 0, errors = 0;
  logic [15:0] ek [1:9][1:6];
  logic [15:0] dk [1:9][1:6];

  always #(CLK_P/2) clk = ~clk;

  idea_iter_core u0 (.clk(clk), .rst_n(rst_n), .start(start), .mode_dec(mode_dec),
    .din(din), .subkeys(subkeys), .key_round(key_round), .key_dec(key_dec),
    .busy(busy), .done(done), .dout(dout));

  always_comb begin
    int ri;
    ri = (key_round >= 4'd1 && key_round <= 4'd9) ? int'(key_round) : 1;
    if (key_dec)
      subkeys = {dk[ri][1], dk[ri][2], dk[ri][3], dk[ri][4], dk[ri][5], dk[ri][6]};
    else
      subkeys = {ek[ri][1], ek[ri][2], ek[ri][3], ek[ri][4], ek[ri][5], ek[ri][6]};
  end

  // R10: zero stands for 65536
  function automatic logic [15:0] mm(input logic [15:0] x, input logic [15:0] y);
    longint xv, yv, r;
    xv = (x == 0) ? 65536 : longint'(x);
    yv = (y == 0) ? 65536 : longint'(y);
    r = (xv * yv) % 65537;
    return (r == 65536) ? 16'h0 : 16'(r);
  endfunction

  function automatic logic [15:0] minv(input logic [15:0] x);
    logic [15:0] r, bse;
    r = 16'd1; bse = x;
    for (int i = 0; i < 16; i++) begin
      r = mm(r, bse);
      bse = mm(bse, bse);
    end
    return r;
  endfunction

  function automatic void schedule(input logic [127:0] key);
    logic [127:0] kk;
    kk = key;
    for (int i = 0; i < 52; i++) begin
      if (i > 0 && i % 8 == 0) kk = {kk[102:0], kk[127:103]};
      ek[i/6+1][i%6+1] = kk[127-16*(i%8) -: 16];
    end
    ek[9][5] = 16'h0; ek[9][6] = 16'h0;
    for (int r = 1; r <= 9; r++) begin
      int j;
      j = 10 - r;
      dk[r][1] = minv(ek[j][1]);
      dk[r][4] = minv(ek[j][4]);
      if (r == 1 || r == 9) begin
        dk[r][2] = 16'(0 - ek[j][2]); dk[r][3] = 16'(0 - ek[j][3]);
      end else begin
        dk[r][2] = 16'(0 - ek[j][3]); dk[r][3] = 16'(0 - ek[j][2]);
      end
      dk[r][5] = (r <= 8) ? ek[9-r][5] : 16'h0;
      dk[r][6] = (r <= 8) ? ek[9-r][6] : 16'h0;
    end
  endfunction

  // R4 R5 R6 reference
  function automatic logic [63:0] model(input logic [63:0] x, input bit dec);
    logic [15:0] w1, w2, w3, w4, p, q, s, u, e0, e1, e2, k[1:6];
    {w1, w2, w3, w4} = x;
    for (int r = 1; r <= 8; r++) begin
      for (int i = 1; i <= 6; i++) k[i] = dec ? dk[r][i] : ek[r][i];
      p = mm(w1, k[1]); q = w2 + k[2]; s = w3 + k[3]; u = mm(w4, k[4]);
      e0 = mm(p ^ s, k[5]);
      e1 = mm(16'(e0 + (q ^ u)), k[6]);
      e2 = e0 + e1;
      w1 = p ^ e1; w4 = u ^ e2;
      if (r == 8) begin w2 = q ^ e2; w3 = s ^ e1; end
      else begin w2 = s ^ e1; w3 = q ^ e2; end
    end
    for (int i = 1; i <= 4; i++) k[i] = dec ? dk[9][i] : ek[9][i];
    return {mm(w1, k[1]), 16'(w2 + k[2]), 16'(w3 + k[3]), mm(w4, k[4])};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_block(input logic [63:0] x, input bit m, input bit poke, output logic [63:0] y);
    @(negedge clk); din = x; mode_dec = m; start = 1'b1;
    @(negedge clk); start = 1'b0; din = ~x;
    chk(busy === 1'b1 && key_round == 4'd1 && key_dec === m, "R2",
        {59'd0, busy, key_round}, {59'd0, 1'b1, 4'd1});
    for (int k = 2; k <= 9; k++) begin
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b1 && key_round == 4'(k) && key_dec === m, poke ? "R7 R3" : "R3",
          {58'd0, key_dec, busy, key_round}, {58'd0, m, 1'b1, 4'(k)});
      if (poke && (k == 4 || k == 9)) begin start = 1'b1; mode_dec = ~m; end
    end
    @(negedge clk); start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0 && key_round == 4'd0, "R6",
        {58'd0, done, busy, key_round}, {58'd0, 2'b10, 4'd0});
    y = dout;
    @(negedge clk);
    chk(done === 1'b0 && dout === y, "R8", dout, y);
  endtask

  logic [63:0] ct, pt, exp_v;

  initial begin
    void'($urandom(32'd7741));
    schedule(128'h0);
    #(CLK_P*3);
    chk(busy === 0 && done === 0 && key_dec === 0 && key_round == 0 && dout == 0, "R1",
        dout, 64'd0);
    @(negedge clk); rst_n = 1'b1;

    schedule(128'h0001_0002_0003_0004_0005_0006_0007_0008);
    run_block(64'h0000_0001_0002_0003, 1'b0, 1'b0, ct);
    chk(ct === 64'h11FB_ED2B_0198_6DE5, "R5", ct, 64'h11FB_ED2B_0198_6DE5);
    run_block(ct, 1'b1, 1'b0, pt);
    chk(pt === 64'h0000_0001_0002_0003, "R9", pt, 64'h0000_0001_0002_0003);

    schedule(128'h0);
    run_block(64'h0, 1'b0, 1'b0, ct);
    exp_v = model(64'h0, 1'b0);
    chk(ct === exp_v, "R10", ct, exp_v);
    schedule({8{16'hFFFF}});
    run_block({4{16'h0000}}, 1'b0, 1'b0, ct);
    exp_v = model(64'h0, 1'b0);
    chk(ct === exp_v, "R10", ct, exp_v);
    run_block({4{16'hFFFF}}, 1'b0, 1'b0, ct);
    exp_v = model({4{16'hFFFF}}, 1'b0);
    chk(ct === exp_v, "R4", ct, exp_v);

    for (int n = 0; n < 24; n++) begin
      logic [63:0] x;
      bit pk;
      schedule({$urandom, $urandom, $urandom, $urandom});
      x = {$urandom, $urandom};
      if (n % 5 == 0) x[47:32] = 16'h0;
      pk = (n % 3 == 0);
      run_block(x, 1'b0, pk, ct);
      exp_v = model(x, 1'b0);
      chk(ct === exp_v, pk ? "R7" : "R4", ct, exp_v);
      for (int h = 0; h < 3; h++) begin
        @(negedge clk); din = {$urandom, $urandom};
        chk(dout === ct && !busy, "R8", dout, ct);
      end
      run_block(ct, 1'b1, pk, pt);
      chk(pt === x, "R9", pt, x);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule